// File: doc/BRIEF.md
# Binary-to-LFSR Count Converter

This block turns a plain binary count into the state that a fixed 16-bit linear feedback shift register reaches after being advanced that many times from its reset value. Timing logic that counts with shallow LFSR counters instead of binary adders needs its compare values in LFSR form. A mode loader, or software through a register wrapper, hands the block a binary count and gets back the value to load into such a comparator.

The generator starts from all ones. Each advance moves the state one bit toward the most significant end and keeps only 16 bits. The new least significant bit is the exclusive-OR of state bits 15, 4, 2 and 1. The converter makes one advance per clock, so a count of N takes N+1 cycles from acceptance to result. No jump-ahead or lookup table is used.

Requests enter on a valid/ready input. `in_ready` is low for the whole conversion, so at most one request is in flight. A request offered while `in_ready` is low is not taken and has no effect. The result side has no back-pressure: `out_valid` pulses for one cycle, and `out_data` holds the result until the next conversion finishes.

Top module: `lfsr_count_conv`

## Requirements
- R1: After reset, `in_ready` is 1, `busy` is 0, `out_valid` is 0 and `out_data` is 16'hFFFF.
- R2: A count of 0 returns 16'hFFFF.
- R3: Each advance computes next = {state[14:0], state[15]^state[4]^state[2]^state[1]}. So counts 1, 2 and 3 return 16'hFFFE, 16'hFFFC and 16'hFFF9.
- R4: For a request with count N accepted at clock edge A, `out_valid` is 1 in the cycle after edge A+N+1, and `out_data` then equals the state after N advances.
- R5: `out_valid` is high for exactly one cycle per accepted request, and `busy` is 0 in that cycle.
- R6: A request offered while `in_ready` is 0 is ignored: it produces no result and does not change the conversion in progress.
- R7: `out_data` changes only in a cycle where `out_valid` is 1.
- R8: `busy` goes high at the acceptance edge and stays high until the edge that raises `out_valid`. `in_ready` is the inverse of `busy`.
- R9: A new request may be accepted at the edge right after the `out_valid` cycle, which gives back-to-back conversions with no idle cycle.
- R10: The full count range is handled, up to 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Converter idle; a request is taken at an edge where in_valid and in_ready are both 1 |
| in_count | input | 16 | Binary count of advances |
| out_valid | output | 1 | One-cycle pulse: result available |
| out_data | output | 16 | Converted LFSR value, held until the next result |
| busy | output | 1 | Conversion in progress |

## Verification
The converter is driven with several kinds of count:
- Counts 0, 1, 2 and 3 have values worked out by hand. They separate a wrong seed, a wrong shift direction and a wrong tap set.
- A spread of mid-range counts is compared with a step-by-step model in the bench. Each result must arrive exactly N+1 cycles after acceptance, which exposes off-by-one errors in the down counter.
- Back-to-back requests and requests offered during a long conversion show whether the input handshake drops, duplicates or corrupts work.
- The largest count, 65535, shows whether the counter truncates its load value.

// File: rtl/lfsr_conv_pkg.sv
package lfsr_conv_pkg;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_LFSR_W = 16;
  // Seed: all ones. Taps: bits 15, 4, 2, 1.
  localparam logic [15:0] DEF_SEED = 16'hFFFF;
  localparam logic [15:0] DEF_TAPS = 16'h8016;

  typedef enum logic {
    CV_IDLE = 1'b0,
    CV_RUN  = 1'b1
  } cv_state_e;
endpackage

// File: rtl/lc_lfsr_core.sv
module lc_lfsr_core #(
  parameter int unsigned  WIDTH = 16,
  parameter logic [WIDTH-1:0] SEED = '1,
  parameter logic [WIDTH-1:0] TAPS = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [WIDTH-1:0] state
);
  // Exclusive-OR chain over the tapped bits, built per bit position.
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign chain[i+1] = chain[i] ^ state[i];
    end else begin : g_off
      assign chain[i+1] = chain[i];
    end
  end

  logic feedback;
  assign feedback = chain[WIDTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (load) begin
      state <= SEED;
    end else if (step) begin
      state <= {state[WIDTH-2:0], feedback};
    end
  end
endmodule

// File: rtl/lc_down_count.sv
module lc_down_count #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [WIDTH-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (dec && (remain != '0)) begin
      remain <= remain - 1'b1;
    end
  end

  assign zero = (remain == '0);
endmodule

// File: rtl/lc_seq_ctrl.sv
module lc_seq_ctrl
  import lfsr_conv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic zero,
  output logic load,
  output logic advance,
  output logic finish,
  output logic busy,
  output logic done_q
);
  cv_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    advance = 1'b0;
    finish  = 1'b0;
    unique case (st_q)
      CV_IDLE: begin
        if (req) begin
          load = 1'b1;
          st_d = CV_RUN;
        end
      end
      CV_RUN: begin
        if (zero) begin
          finish = 1'b1;
          st_d   = CV_IDLE;
        end else begin
          advance = 1'b1;
        end
      end
      default: st_d = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CV_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  assign busy = (st_q == CV_RUN);
endmodule

// File: rtl/lfsr_count_conv.sv
module lfsr_count_conv
  import lfsr_conv_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned LFSR_W = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] SEED = DEF_SEED,
  parameter logic [LFSR_W-1:0] TAPS = DEF_TAPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CNT_W-1:0]  in_count,
  output logic              out_valid,
  output logic [LFSR_W-1:0] out_data,
  output logic              busy
);
  logic req, zero, load, advance, finish, done_q, busy_i;
  logic [LFSR_W-1:0] work;

  assign req = in_valid && !busy_i;

  lc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .zero(zero),
    .load(load), .advance(advance), .finish(finish),
    .busy(busy_i), .done_q(done_q)
  );

  lc_down_count #(.WIDTH(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(in_count),
    .dec(advance), .zero(zero)
  );

  lc_lfsr_core #(.WIDTH(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(advance), .state(work)
  );

  // The result register updates only when a conversion finishes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= SEED;
    end else if (finish) begin
      out_data <= work;
    end
  end

  assign out_valid = done_q;
  assign busy      = busy_i;
  assign in_ready  = !busy_i;
endmodule

// File: rtl/lfsr_count_conv_chk.sv
module lfsr_count_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_count,
  input logic        out_valid,
  input logic [15:0] out_data,
  input logic        busy
);
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_count == 16'd0) |=> ##1 (out_valid && out_data == 16'hFFFF)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy); // R5

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy); // R8

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid); // R8
endmodule

bind lfsr_count_conv lfsr_count_conv_chk u_chk (.*);

// File: tb/sim_lfsr_count_conv.sv
`timescale 1ns/1ps
module sim_lfsr_count_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_count = '0;
  logic        in_ready, out_valid, busy;
  logic [15:0] out_data;

  int    n_chk = 0;
  int    n_fail = 0;
  longint cyc = 0;
  bit    finished = 1'b0;

  logic [15:0] exp_q[$];
  longint      due_q[$];
  string       tag_q[$];
  logic [15:0] prev_data = 16'hFFFF;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lfsr_count_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_count(in_count), .out_valid(out_valid), .out_data(out_data), .busy(busy)
  );

  function automatic logic [15:0] ref_lfsr(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: offer one request, push expectation on acceptance.
  task automatic send(input int n, input string req);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_count = n[15:0];
    exp_q.push_back(ref_lfsr(n));
    due_q.push_back(cyc + 1 + n + 1);
    tag_q.push_back(req);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare results in order; R7 stability each cycle.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(in_ready == !busy, "R8", in_ready, !busy);
      if (out_valid) begin
        check(!busy, "R5", busy, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", out_data, 0);
        end else begin
          logic [15:0] e;
          longint d;
          string t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
          check(cyc == d, "R4", cyc, d);
        end
      end else if (out_data != prev_data) begin
        check(1'b0, "R7", out_data, prev_data);
      end
      prev_data = out_data;
    end
  end

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R1", in_ready, 1);
    check(busy === 1'b0, "R1", busy, 0);
    check(out_valid === 1'b0, "R1", out_valid, 0);
    check(out_data === 16'hFFFF, "R1", out_data, 16'hFFFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 and R3: known values
    send(0, "R2"); drain();
    check(out_data == 16'hFFFF, "R2", out_data, 16'hFFFF);
    send(1, "R3"); drain();
    check(out_data == 16'hFFFE, "R3", out_data, 16'hFFFE);
    send(2, "R3"); drain();
    check(out_data == 16'hFFFC, "R3", out_data, 16'hFFFC);
    send(3, "R3"); drain();
    check(out_data == 16'hFFF9, "R3", out_data, 16'hFFF9);

    // R4: spread of counts against the model
    for (int i = 0; i < 12; i++) send(i * 37 + 5, "R4");
    drain();

    // R9: back-to-back, accepted right after each result
    send(7, "R9"); send(0, "R9"); send(20, "R9"); send(1, "R9");
    drain();

    // R6: requests offered while busy are ignored
    send(40, "R6");
    for (int i = 0; i < 10; i++) begin
      in_valid = 1'b1;
      in_count = 16'd5;
      check(in_ready == 1'b0, "R8", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    check(out_data == ref_lfsr(40), "R6", out_data, ref_lfsr(40));

    // R10: largest count
    send(65535, "R10");
    drain();
    check(out_data == ref_lfsr(65535), "R10", out_data, ref_lfsr(65535));
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end
endmodule